// File: doc/BRIEF.md
# Shaped On/Off Keying Amplitude Ramp

This block scales a 12-bit sample stream by a 12-bit amplitude factor, so that a burst can rise and fall smoothly rather than switching on and off at once. The result is registered, so each output sample appears one clock after the input sample and the factor that produced it.

The factor has two possible sources. In internal mode it comes from an amplitude counter that moves one code per step. A reloading rate counter sets the pace of the steps, and a keying input sets whether the amplitude rises or falls. In user mode the factor is a programmable shape value that is supplied on a port. When the enable input is low, the multiplier is bypassed and the sample passes through at full scale.

The rate counter and the amplitude counter run all the time, whatever the mode. Switching into internal mode therefore picks up the ramp at its current level.

Top module: `osk_amp_ramp`

## Requirements
- R1: While `shape_en` is 0, `sig_out` equals the `sig_in` value sampled at the previous rising edge, whatever the factor.
- R2: While `shape_en` is 1 and `ramp_mode` is 0, `sig_out` is floor(`sig_in` × `user_level` / 4096). When `user_level` is 4095, `sig_out` equals `sig_in` exactly.
- R3: While `shape_en` is 1 and `ramp_mode` is 1, the factor is the internal amplitude counter, and the same scaling as in R2 applies, including the exact pass-through at 4095.
- R4: With rate value N on `ramp_rate`, the amplitude counter takes its first step at the (N+1)-th rising edge after reset is released. It then steps once every N+1 edges, with N taken from 0 to 255.
- R5: On each step with `key_in` at 1, the amplitude counter rises by one. It holds at 4095 and never wraps to 0.
- R6: On each step with `key_in` at 0, the amplitude counter falls by one. It holds at 0 and never wraps to 4095.
- R7: A rising edge with `rst_n` at 0 clears `sig_out` and the amplitude counter to 0 and loads the rate counter with `ramp_rate`.
- R8: `sig_out` is registered: it changes only at a rising edge and reflects the inputs and the factor present before that edge.
- R9: A factor of 0 in either user or internal mode gives an output of 0 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| shape_en | input | 1 | 1: apply the amplitude factor; 0: full-scale bypass |
| ramp_mode | input | 1 | 1: internal ramp counter as factor; 0: `user_level` as factor |
| ramp_rate | input | 8 | Rate value N; the step interval is N+1 clocks |
| user_level | input | 12 | User shape factor |
| key_in | input | 1 | Ramp direction: 1 up, 0 down |
| sig_in | input | 12 | Unsigned sample in |
| sig_out | output | 12 | Scaled sample out |

## Verification
Every sample result is due one rising edge after its inputs. The bench therefore changes inputs on a falling edge and compares on the next falling edge, and it also confirms that nothing has moved a moment after the inputs change. Ramp results are counted in edges from the release of reset. The level seen after edge e is the scaling of floor((e-1)/(N+1)), clipped to the range 0 to 4095, because the step taken at edge e shows up only at the following edge. The bench drives a full-scale input and derives each expected sample from that arithmetic. It covers the rates 0, 3 and 255 and a complete rise followed by a complete fall through both saturation points.

// File: rtl/osk_amp_ramp.sv
module osk_amp_ramp #(
  parameter int DW = 12,
  parameter int AW = 12,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shape_en,
  input  logic          ramp_mode,
  input  logic [RW-1:0] ramp_rate,
  input  logic [AW-1:0] user_level,
  input  logic          key_in,
  input  logic [DW-1:0] sig_in,
  output logic [DW-1:0] sig_out
);
  localparam int PW = DW + AW;
  localparam logic [AW-1:0] AMP_MAX = '1;

  logic [RW-1:0] pace_cnt;
  logic [AW-1:0] amp_cnt;
  logic          step;
  logic [AW-1:0] factor;
  logic [PW-1:0] prod;
  logic [DW-1:0] next_out;

  assign step = (pace_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    pace_cnt <= ramp_rate;
    else if (step) pace_cnt <= ramp_rate;
    else           pace_cnt <= pace_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amp_cnt <= '0;
    end else if (step) begin
      if (key_in && amp_cnt != AMP_MAX) amp_cnt <= amp_cnt + 1'b1;
      else if (!key_in && amp_cnt != '0) amp_cnt <= amp_cnt - 1'b1;
    end
  end

  assign factor   = ramp_mode ? amp_cnt : user_level;
  assign prod     = {{AW{1'b0}}, sig_in} * {{DW{1'b0}}, factor};
  assign next_out = (!shape_en || factor == AMP_MAX) ? sig_in : prod[PW-1:AW];

  always_ff @(posedge clk) begin
    if (!rst_n) sig_out <= '0;
    else        sig_out <= next_out;
  end
endmodule

module osk_amp_ramp_chk #(
  parameter int DW = 12,
  parameter int AW = 12,
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shape_en,
  input logic          ramp_mode,
  input logic [RW-1:0] ramp_rate,
  input logic [AW-1:0] user_level,
  input logic          key_in,
  input logic [DW-1:0] sig_in,
  input logic [DW-1:0] sig_out,
  input logic [RW-1:0] pace_cnt,
  input logic [AW-1:0] amp_cnt
);
  localparam logic [AW-1:0] AMP_MAX = '1;

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !shape_en |=> sig_out == $past(sig_in));

  p_user_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shape_en && !ramp_mode && user_level == AMP_MAX) |=> sig_out == $past(sig_in));

  p_zero_factor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (shape_en && ((!ramp_mode && user_level == '0) || (ramp_mode && amp_cnt == '0)))
      |=> sig_out == '0);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pace_cnt != '0 |=> $stable(amp_cnt));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pace_cnt == '0 |=> pace_cnt == $past(ramp_rate));

  p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_cnt == AMP_MAX && key_in) |=> amp_cnt == AMP_MAX);

  p_sat_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_cnt == '0 && !key_in) |=> amp_cnt == '0);

  p_up_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_cnt == '0 && key_in && amp_cnt != AMP_MAX) |=> amp_cnt == $past(amp_cnt) + 1'b1);

  p_down_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_cnt == '0 && !key_in && amp_cnt != '0) |=> amp_cnt == $past(amp_cnt) - 1'b1);
endmodule

bind osk_amp_ramp osk_amp_ramp_chk #(.DW(DW), .AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .shape_en(shape_en), .ramp_mode(ramp_mode),
  .ramp_rate(ramp_rate), .user_level(user_level), .key_in(key_in),
  .sig_in(sig_in), .sig_out(sig_out), .pace_cnt(pace_cnt), .amp_cnt(amp_cnt)
);

// File: tb/tb_osk_amp_ramp.sv
module tb_osk_amp_ramp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shape_en = 1'b0;
  logic        ramp_mode = 1'b0;
  logic [7:0]  ramp_rate = 8'd0;
  logic [11:0] user_level = 12'd0;
  logic        key_in = 1'b0;
  logic [11:0] sig_in = 12'd0;
  logic [11:0] sig_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  osk_amp_ramp dut (
    .clk(clk), .rst_n(rst_n), .shape_en(shape_en), .ramp_mode(ramp_mode),
    .ramp_rate(ramp_rate), .user_level(user_level), .key_in(key_in),
    .sig_in(sig_in), .sig_out(sig_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_scale(int a, int f);
    if (f >= 4095) return a;
    return (a * f) / 4096;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start(int rate, bit key, bit en, bit mode, int din);
    @(negedge clk);
    rst_n = 1'b0; ramp_rate = rate[7:0]; key_in = key;
    shape_en = en; ramp_mode = mode; sig_in = din[11:0];
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ramp_run(string req, int rate, int edges);
    for (int e = 1; e <= edges; e++) begin
      @(posedge clk); @(negedge clk);
      begin
        int lvl;
        lvl = (e - 1) / (rate + 1);
        if (lvl > 4095) lvl = 4095;
        check(req, sig_out, exp_scale(4095, lvl));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: reset state, with a non-zero input present
    start(3, 1'b1, 1'b0, 1'b0, 4000);
    check("R7", sig_out, 0);

    // R1 bypass sweep, R8 output changes only at the edge
    for (int v = 0; v < 4096; v++) begin
      int prev;
      prev = sig_out;
      sig_in = v[11:0];
      user_level = 12'(v * 5);
      #1;
      check("R8", sig_out, prev);
      @(posedge clk); @(negedge clk);
      check("R1", sig_out, v);
    end

    // R2 user shape sweep, R9 zero factor
    shape_en = 1'b1; ramp_mode = 1'b0;
    for (int l = 0; l <= 4095 + 7; l += 7) begin
      int lv;
      lv = (l > 4095) ? 4095 : l;
      for (int k = 0; k < 6; k++) begin
        int din;
        case (k)
          0: din = 0;
          1: din = 1;
          2: din = 2048;
          3: din = 4095;
          4: din = 1234;
          default: din = 3001;
        endcase
        user_level = lv[11:0]; sig_in = din[11:0];
        @(posedge clk); @(negedge clk);
        if (lv == 0) check("R9", sig_out, 0);
        else check("R2", sig_out, exp_scale(din, lv));
      end
    end

    // R3/R4 internal ramp with N = 3, first step at edge 4
    start(3, 1'b1, 1'b1, 1'b1, 4095);
    check("R7", sig_out, 0);
    ramp_run("R4", 3, 60);

    // R4 slowest rate N = 255
    start(255, 1'b1, 1'b1, 1'b1, 4095);
    ramp_run("R4", 255, 800);

    // R3/R5 full rise with N = 0, saturating at the top
    start(0, 1'b1, 1'b1, 1'b1, 4095);
    ramp_run("R5", 0, 4300);

    // R6 full fall, saturating at zero
    key_in = 1'b0;
    for (int d = 1; d <= 4300; d++) begin
      int lvl;
      @(posedge clk); @(negedge clk);
      lvl = 4096 - d;
      if (lvl < 0) lvl = 0;
      check("R6", sig_out, exp_scale(4095, lvl));
    end

    // R9 internal factor at zero with a large input
    sig_in = 12'd3333;
    @(posedge clk); @(negedge clk);
    check("R9", sig_out, 0);

    // R3 internal level mid-scale on a non-trivial input
    start(0, 1'b1, 1'b1, 1'b1, 2000);
    repeat (1001) @(posedge clk);
    @(negedge clk);
    check("R3", sig_out, exp_scale(2000, 1000));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule